// File: doc/BRIEF.md
# Auxiliary Time Snapshot and Event Unit

This block takes a running 64-bit system time and two asynchronous external event inputs. One input belongs to a slave-side channel and the other to a master-side channel. Each input passes through a synchroniser. On the rising edge of an input, the block copies the full system time into that channel's snapshot. The copy is presented as a low word and a high word, and it stays frozen until the next rising edge on the same channel.

A shared event word records four conditions: a target-time match, the two snapshot captures, and a pulse-per-second tick. The target-time match and the pulse-per-second tick come from other logic as one-cycle pulses. Software clears an event bit by writing a one to it. An enable word with the same bit layout selects which events drive a single level-sensitive interrupt line.

The register bus decode sits outside this block. It presents a write strobe and data for the event word and for the enable word, and it reads the outputs directly. The reset input is asynchronous and active low. It must be released synchronously to the clock by the reset logic upstream.

Top module: `aux_snap_unit`

## Requirements
- R1: After reset, the event word, the enable word, all four snapshot words and the interrupt line are zero.
- R2: A rising edge on the slave input is seen through a two-flop synchroniser. The system time present at the third clock edge after the input rises is captured: bits 31:0 go into the slave low word and bits 63:32 into the slave high word. At that same edge, event bit 2 is set.
- R3: A rising edge on the master input is captured the same way into the master low and high words, and it sets event bit 3. The slave channel is left untouched.
- R4: A one-cycle pulse on the target-match input sets event bit 1. A one-cycle pulse on the pulse-per-second input sets event bit 4.
- R5: A write to the event word clears every bit written as one. Bits written as zero keep their value. Several bits may be cleared in one write. Bits 0 and 5 to 31 always read zero.
- R6: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R7: A snapshot holds its value while the system time moves on. It also holds while the input stays high and when the input falls. It changes only on the next rising edge.
- R8: A rising edge while the channel's event bit is still set overwrites the snapshot with the new time, and the bit stays set.
- R9: The enable word uses bit 1 for target match, bit 2 for slave capture, bit 3 for master capture and bit 4 for pulse-per-second. Its other bits read zero. The interrupt line is high exactly when some event bit and its enable bit are both set.
- R10: Once high, the interrupt line stays high until software clears the event bit or its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_time | input | 64 | Running system time |
| aux_slv_in | input | 1 | Asynchronous slave-channel event input |
| aux_mst_in | input | 1 | Asynchronous master-channel event input |
| tgt_hit | input | 1 | One-cycle target-time-match pulse |
| pps_tick | input | 1 | One-cycle pulse-per-second pulse |
| evt_wr | input | 1 | Write strobe for the event word (write one to clear) |
| evt_wdata | input | 32 | Write data for the event word |
| ena_wr | input | 1 | Write strobe for the enable word |
| ena_wdata | input | 32 | Write data for the enable word |
| evt_word | output | 32 | Event status word |
| ena_word | output | 32 | Interrupt enable word |
| slv_snap_lo | output | 32 | Slave snapshot, bits 31:0 |
| slv_snap_hi | output | 32 | Slave snapshot, bits 63:32 |
| mst_snap_lo | output | 32 | Master snapshot, bits 31:0 |
| mst_snap_hi | output | 32 | Master snapshot, bits 63:32 |
| irq | output | 1 | Level interrupt |

## Verification
Capture is tried with time values that differ in both the high and the low word. A swapped or truncated word therefore shows up in the result. Each channel is fired on its own, so a crossed channel is caught by the snapshot that should not move. Capture is also tried with the input held high and with the input falling, which separates edge detection from level sensing. A repeat edge before any clear is then applied to confirm overwrite without losing the flag. Write-one-to-clear is tried with single-bit, multi-bit and all-zero data, and with a set and a clear colliding in one cycle. The interrupt is checked with the enable word fully open, fully closed and opened one bit at a time.

// File: rtl/aux_snap_pkg.sv
package aux_snap_pkg;
  localparam int WORD_W  = 32;
  localparam int TIME_W  = 64;
  localparam int N_CHAN  = 2;
  // event word bit positions (decoded by software)
  localparam int TGT_BIT = 1;
  localparam int SLV_BIT = 2;
  localparam int MST_BIT = 3;
  localparam int PPS_BIT = 4;
  localparam logic [WORD_W-1:0] EVT_USED =
    (WORD_W'(1) << TGT_BIT) | (WORD_W'(1) << SLV_BIT) |
    (WORD_W'(1) << MST_BIT) | (WORD_W'(1) << PPS_BIT);
endpackage

// File: rtl/aux_edge_sync.sv
module aux_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/snap_channel.sv
module snap_channel #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [TIME_W-1:0] time_in,
  output logic [TIME_W-1:0] snap
);
  logic [TIME_W-1:0] snap_q, snap_d;

  always_comb begin
    snap_d = snap_q;
    if (cap) snap_d = time_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else if (cap) snap_q <= snap_d;
  end

  assign snap = snap_q;

  // R2
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (snap == $past(time_in)));
endmodule

// File: rtl/event_status.sv
module event_status
  import aux_snap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_vec,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ena_wr,
  input  logic [WORD_W-1:0] ena_wdata,
  output logic [WORD_W-1:0] evt,
  output logic [WORD_W-1:0] ena,
  output logic              irq
);
  logic [WORD_W-1:0] evt_q, evt_d, ena_q, ena_d, clr_vec;

  always_comb begin
    clr_vec = wr ? (wdata & EVT_USED) : '0;
    // set has priority over clear
    evt_d   = ((evt_q & ~clr_vec) | set_vec) & EVT_USED;
    ena_d   = ena_wr ? (ena_wdata & EVT_USED) : ena_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      ena_q <= '0;
    end else begin
      evt_q <= evt_d;
      if (ena_wr) ena_q <= ena_d;
    end
  end

  assign evt = evt_q;
  assign ena = ena_q;
  assign irq = |(evt_q & ena_q);

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit_chk
    if (EVT_USED[b]) begin : g_used
      // R6
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[b] |=> evt[b]);
      // R5
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[b] && !set_vec[b]) |=> !evt[b]);
      // R5
      zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[b] && !(wr && wdata[b])) |=> evt[b]);
    end else begin : g_unused
      // R5
      unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt[b] && !ena[b]);
    end
  end
endmodule

// File: rtl/aux_snap_unit.sv
module aux_snap_unit
  import aux_snap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       sys_time,
  input  logic              aux_slv_in,
  input  logic              aux_mst_in,
  input  logic              tgt_hit,
  input  logic              pps_tick,
  input  logic              evt_wr,
  input  logic [31:0]       evt_wdata,
  input  logic              ena_wr,
  input  logic [31:0]       ena_wdata,
  output logic [31:0]       evt_word,
  output logic [31:0]       ena_word,
  output logic [31:0]       slv_snap_lo,
  output logic [31:0]       slv_snap_hi,
  output logic [31:0]       mst_snap_lo,
  output logic [31:0]       mst_snap_hi,
  output logic              irq
);
  localparam int CH_SLV = 0;
  localparam int CH_MST = 1;
  localparam int CH_BIT [N_CHAN] = '{SLV_BIT, MST_BIT};

  logic [N_CHAN-1:0]  ch_in, ch_rise;
  logic [TIME_W-1:0]  ch_snap [N_CHAN];
  logic [WORD_W-1:0]  set_vec;

  assign ch_in[CH_SLV] = aux_slv_in;
  assign ch_in[CH_MST] = aux_mst_in;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    aux_edge_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ch_in[c]), .rise(ch_rise[c]));
    snap_channel #(.TIME_W(TIME_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .cap(ch_rise[c]), .time_in(sys_time),
      .snap(ch_snap[c]));
  end

  always_comb begin
    set_vec = '0;
    set_vec[TGT_BIT] = tgt_hit;
    set_vec[PPS_BIT] = pps_tick;
    for (int c = 0; c < N_CHAN; c++) set_vec[CH_BIT[c]] = ch_rise[c];
  end

  event_status u_evt (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .wr(evt_wr), .wdata(evt_wdata),
    .ena_wr(ena_wr), .ena_wdata(ena_wdata),
    .evt(evt_word), .ena(ena_word), .irq(irq));

  assign slv_snap_lo = ch_snap[CH_SLV][WORD_W-1:0];
  assign slv_snap_hi = ch_snap[CH_SLV][TIME_W-1:WORD_W];
  assign mst_snap_lo = ch_snap[CH_MST][WORD_W-1:0];
  assign mst_snap_hi = ch_snap[CH_MST][TIME_W-1:WORD_W];

  // R7
  slv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_rise[CH_SLV] |=> ($stable(slv_snap_lo) && $stable(slv_snap_hi)));
  // R3
  mst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_rise[CH_MST] |=> ($stable(mst_snap_lo) && $stable(mst_snap_hi)));
  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !evt_wr && !ena_wr) |=> irq);
  // R8
  flag_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rise[CH_SLV] && evt_word[SLV_BIT]) |=> evt_word[SLV_BIT]);
endmodule

// File: tb/aux_snap_unit_test.sv
module aux_snap_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] sys_time;
  logic        aux_slv_in, aux_mst_in, tgt_hit, pps_tick, evt_wr, ena_wr;
  logic [31:0] evt_wdata, ena_wdata;
  logic [31:0] evt_word, ena_word, slv_snap_lo, slv_snap_hi, mst_snap_lo, mst_snap_hi;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_snap_unit uut (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
    .aux_slv_in(aux_slv_in), .aux_mst_in(aux_mst_in),
    .tgt_hit(tgt_hit), .pps_tick(pps_tick),
    .evt_wr(evt_wr), .evt_wdata(evt_wdata),
    .ena_wr(ena_wr), .ena_wdata(ena_wdata),
    .evt_word(evt_word), .ena_word(ena_word),
    .slv_snap_lo(slv_snap_lo), .slv_snap_hi(slv_snap_hi),
    .mst_snap_lo(mst_snap_lo), .mst_snap_hi(mst_snap_hi), .irq(irq));

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_evt(input logic [31:0] d);
    evt_wr = 1'b1; evt_wdata = d; step(); evt_wr = 1'b0; evt_wdata = '0;
  endtask

  task automatic set_ena(input logic [31:0] d);
    ena_wr = 1'b1; ena_wdata = d; step(); ena_wr = 1'b0; ena_wdata = '0;
  endtask

  task automatic t_reset;
    check("R1 evt", {32'h0, evt_word}, 64'h0);
    check("R1 ena", {32'h0, ena_word}, 64'h0);
    check("R1 slv", {slv_snap_hi, slv_snap_lo}, 64'h0);
    check("R1 mst", {mst_snap_hi, mst_snap_lo}, 64'h0);
    check("R1 irq", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_slave;
    sys_time = 64'h1234_5678_9ABC_DEF0;
    aux_slv_in = 1'b1;
    step(2);
    check("R2 no capture before sync", {slv_snap_hi, slv_snap_lo}, 64'h0);
    step();
    check("R2 slave snapshot", {slv_snap_hi, slv_snap_lo}, 64'h1234_5678_9ABC_DEF0);
    check("R2 slave flag", {32'h0, evt_word}, 64'h4);
    check("R3 master untouched", {mst_snap_hi, mst_snap_lo}, 64'h0);
  endtask

  task automatic t_hold;
    sys_time = 64'hAAAA_0000_5555_1111;
    step(4);
    check("R7 held while input high", {slv_snap_hi, slv_snap_lo}, 64'h1234_5678_9ABC_DEF0);
    aux_slv_in = 1'b0;
    step(4);
    check("R7 held after fall", {slv_snap_hi, slv_snap_lo}, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_master;
    sys_time = 64'h0F0F_F0F0_0000_0077;
    aux_mst_in = 1'b1;
    step(3);
    aux_mst_in = 1'b0;
    check("R3 master snapshot", {mst_snap_hi, mst_snap_lo}, 64'h0F0F_F0F0_0000_0077);
    check("R3 master flag", {32'h0, evt_word}, 64'hC);
    check("R3 slave unchanged", {slv_snap_hi, slv_snap_lo}, 64'h1234_5678_9ABC_DEF0);
    step(3);
  endtask

  task automatic t_overwrite;
    sys_time = 64'hFEDC_BA98_7654_3210;
    aux_slv_in = 1'b1;
    step(3);
    aux_slv_in = 1'b0;
    check("R8 overwrite value", {slv_snap_hi, slv_snap_lo}, 64'hFEDC_BA98_7654_3210);
    check("R8 flag still set", {63'h0, evt_word[2]}, 64'h1);
    step(3);
  endtask

  task automatic t_events_w1c;
    tgt_hit = 1'b1; step(); tgt_hit = 1'b0;
    check("R4 target bit1", {32'h0, evt_word}, 64'h0E);
    pps_tick = 1'b1; step(); pps_tick = 1'b0;
    check("R4 pps bit4", {32'h0, evt_word}, 64'h1E);
    clear_evt(32'h0);
    check("R5 zero write no effect", {32'h0, evt_word}, 64'h1E);
    clear_evt(32'h4);
    check("R5 single clear", {32'h0, evt_word}, 64'h1A);
    clear_evt(32'hFFFF_FFFF);
    check("R5 multi clear", {32'h0, evt_word}, 64'h0);
    tgt_hit = 1'b1; evt_wr = 1'b1; evt_wdata = 32'h2;
    step();
    tgt_hit = 1'b0; evt_wr = 1'b0; evt_wdata = '0;
    check("R6 set wins", {32'h0, evt_word}, 64'h2);
    clear_evt(32'h2);
    check("R5 cleared after collision", {32'h0, evt_word}, 64'h0);
  endtask

  task automatic t_irq;
    tgt_hit = 1'b1; step(); tgt_hit = 1'b0;
    check("R9 masked no irq", {63'h0, irq}, 64'h0);
    set_ena(32'hFFFF_FFFF);
    check("R9 enable word readback", {32'h0, ena_word}, 64'h1E);
    check("R9 irq when enabled", {63'h0, irq}, 64'h1);
    step(5);
    check("R10 irq stays high", {63'h0, irq}, 64'h1);
    clear_evt(32'h2);
    check("R10 irq drops on clear", {63'h0, irq}, 64'h0);
    set_ena(32'h2);
    pps_tick = 1'b1; step(); pps_tick = 1'b0;
    check("R9 other bit disabled", {63'h0, irq}, 64'h0);
    set_ena(32'h10);
    check("R9 pps enabled", {63'h0, irq}, 64'h1);
    set_ena(32'h0);
    check("R10 irq drops on disable", {63'h0, irq}, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    sys_time = '0; aux_slv_in = 0; aux_mst_in = 0; tgt_hit = 0; pps_tick = 0;
    evt_wr = 0; evt_wdata = '0; ena_wr = 0; ena_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_slave();
    t_hold();
    t_master();
    t_overwrite();
    t_events_w1c();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule